// File: doc/BRIEF.md
# Arithmetic Execute Stage with Flag State

This block is the execute stage of a small 16-bit processor pipeline. Each accepted instruction is one of five operations: copy, add, subtract, compare and a conditional relative branch taken when the last result was non-zero. The decoder and operand-fetch logic upstream supply the opcode, the destination and source operand values, a description of where each operand lives, a signed branch displacement and the instruction length. The block works out the operation width from the operand description. It computes the result and registers a write-back value with its enable and width. It also keeps the zero flag, the sign flag and the instruction pointer.

Every output is registered. The effect of an instruction accepted on a rising edge with `in_valid` high is visible right after that edge. Cycles with `in_valid` low change nothing. An opcode outside the five, or an operand combination whose width cannot be resolved, raises `err` for one cycle and leaves all architectural state untouched.

Top module: `exec_unit`

## Requirements
- R1: Opcode 0 (copy) registers the source value, truncated to the resolved width, on `wb_data` with `wb_en` high, and leaves `zf` and `sf` unchanged.
- R2: Opcode 1 (add) registers destination plus source and opcode 2 (subtract) registers destination minus source on `wb_data` with `wb_en` high, both modulo the resolved width.
- R3: Opcode 3 (compare) computes destination minus source and updates the flags, but keeps `wb_en` low.
- R4: After add, subtract or compare, `zf` is 1 exactly when the result is zero. In byte width the result is cut to 8 bits before this test, and the upper byte of `wb_data` reads 0.
- R5: After add, subtract or compare, `sf` equals result bit 15 in word width and result bit 7 in byte width.
- R6: Width (`wb_wide`, 1 = word) comes from `dst_reg_wide` when `dst_is_reg` is 1. Otherwise it depends on `src_kind`: 0 (register) takes `src_reg_wide`, 1 (8-bit immediate) gives byte, and 2 (16-bit immediate) gives word.
- R7: Opcode 4 (branch) adds the signed `jmp_off` to `ip` when `zf` is 0, and in that case `ip` does not also advance by the length.
- R8: For every accepted instruction other than a taken branch, `ip` advances by `inst_len`.
- R9: An opcode of 5, 6 or 7, or a non-branch instruction with `dst_is_reg` = 0 and `src_kind` = 3 (memory), drives `err` high for one cycle. It keeps `wb_en` low and leaves `ip`, `zf`, `sf`, `wb_data` and `wb_wide` unchanged.
- R10: Reset sets `ip`, `zf`, `sf`, `wb_en`, `wb_data`, `wb_wide` and `err` to zero.
- R11: A cycle with `in_valid` low leaves `ip`, the flags and `wb_data` unchanged and drives `wb_en` and `err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| op | input | 3 | 0 copy, 1 add, 2 subtract, 3 compare, 4 branch if non-zero |
| dst_is_reg | input | 1 | Destination operand is a register |
| dst_reg_wide | input | 1 | Destination register is word sized |
| src_kind | input | 2 | 0 register, 1 imm8, 2 imm16, 3 memory |
| src_reg_wide | input | 1 | Source register is word sized |
| dst_val | input | DATA_W | Destination operand value |
| src_val | input | DATA_W | Source operand value |
| jmp_off | input | DATA_W | Signed branch displacement |
| inst_len | input | LEN_W | Length of the current instruction |
| wb_en | output | 1 | Write-back of `wb_data` requested |
| wb_data | output | DATA_W | Result value |
| wb_wide | output | 1 | Result width, 1 = word |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| ip | output | DATA_W | Instruction pointer |
| err | output | 1 | Unsupported instruction seen |

## Verification
The assertions assume that `op`, the operand description and the values are stable and known whenever `in_valid` is high. They also assume that the upstream stage never needs a result before the edge after issue. The stimulus drives every input on the falling edge and holds it through the following rising edge. It presents one instruction per cycle or an idle cycle, and lowers `in_valid` when it has nothing to send. The stimulus uses only the documented encodings, apart from the deliberate illegal opcode and the memory-to-memory case.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              dst_is_reg,
  input  logic              dst_reg_wide,
  input  logic [1:0]        src_kind,
  input  logic              src_reg_wide,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] jmp_off,
  input  logic [LEN_W-1:0]  inst_len,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_wide,
  output logic              zf,
  output logic              sf,
  output logic [DATA_W-1:0] ip,
  output logic              err
);
  localparam int BYTE_W = 8;
  localparam logic [2:0] OP_MOV = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2,
                         OP_CMP = 3'd3, OP_JNE = 3'd4;
  localparam logic [1:0] SK_REG = 2'd0, SK_IMM8 = 2'd1, SK_IMM16 = 2'd2;

  logic              wide_c, width_ok;
  logic              is_alu, is_jne, bad;
  logic [DATA_W-1:0] raw, res_c, ip_next;

  always_comb begin
    width_ok = 1'b1;
    if (dst_is_reg) wide_c = dst_reg_wide;
    else begin
      case (src_kind)
        SK_REG:   wide_c = src_reg_wide;
        SK_IMM8:  wide_c = 1'b0;
        SK_IMM16: wide_c = 1'b1;
        default: begin wide_c = 1'b0; width_ok = 1'b0; end
      endcase
    end
  end

  assign is_alu = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  assign is_jne = (op == OP_JNE);
  assign bad    = (op > OP_JNE) || (!is_jne && !width_ok);

  always_comb begin
    case (op)
      OP_ADD:  raw = dst_val + src_val;
      OP_MOV:  raw = src_val;
      default: raw = dst_val - src_val;
    endcase
  end

  assign res_c   = wide_c ? raw : {{(DATA_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
  assign ip_next = (is_jne && !zf) ? ip + jmp_off
                                   : ip + {{(DATA_W-LEN_W){1'b0}}, inst_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_data <= '0;
      wb_wide <= 1'b0;
      zf      <= 1'b0;
      sf      <= 1'b0;
      ip      <= '0;
      err     <= 1'b0;
    end else if (in_valid && bad) begin
      wb_en <= 1'b0;
      err   <= 1'b1;
    end else if (in_valid) begin
      err <= 1'b0;
      ip  <= ip_next;
      wb_en <= !is_jne && (op != OP_CMP);
      if (!is_jne) begin
        wb_data <= res_c;
        wb_wide <= wide_c;
      end
      if (is_alu) begin
        zf <= (res_c == '0);
        sf <= wide_c ? res_c[DATA_W-1] : res_c[BYTE_W-1];
      end
    end else begin
      wb_en <= 1'b0;
      err   <= 1'b0;
    end
  end

  a_r1_mov_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_MOV && !bad |=> $stable(zf) && $stable(sf) && wb_en);
  a_r3_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CMP |=> !wb_en);
  a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_alu && !bad |=> zf == (wb_data == '0));
  a_r5_sign_by_width: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_alu && !bad |=> sf == (wb_wide ? wb_data[DATA_W-1] : wb_data[BYTE_W-1]));
  a_r7_jne_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_jne && zf |=> ip == $past(ip) + {{(DATA_W-LEN_W){1'b0}}, $past(inst_len)});
  a_r9_error_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bad |=> err && !wb_en && $stable(ip) && $stable(zf) && $stable(sf) && $stable(wb_data));
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_en && !err && $stable(ip) && $stable(zf) && $stable(sf));
endmodule

// File: tb/exec_unit_tb.sv
module exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        dst_is_reg = 1'b0, dst_reg_wide = 1'b0, src_reg_wide = 1'b0;
  logic [1:0]  src_kind = '0;
  logic [15:0] dst_val = '0, src_val = '0, jmp_off = '0;
  logic [3:0]  inst_len = '0;
  logic        wb_en, wb_wide, zf, sf, err;
  logic [15:0] wb_data, ip;

  int checks = 0, failures = 0;

  typedef struct {
    logic        wb_en;
    logic [15:0] wb_data;
    logic        wb_wide;
    logic        zf;
    logic        sf;
    logic [15:0] ip;
    logic        err;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic        m_zf = 0, m_sf = 0, m_wide = 0;
  logic [15:0] m_ip = 0, m_wb = 0;

  always #5 clk = ~clk;

  exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .dst_is_reg(dst_is_reg), .dst_reg_wide(dst_reg_wide), .src_kind(src_kind),
    .src_reg_wide(src_reg_wide), .dst_val(dst_val), .src_val(src_val),
    .jmp_off(jmp_off), .inst_len(inst_len), .wb_en(wb_en), .wb_data(wb_data),
    .wb_wide(wb_wide), .zf(zf), .sf(sf), .ip(ip), .err(err));

  task automatic issue(input logic v, input logic [2:0] o, input logic dr, input logic dw,
                       input logic [1:0] sk, input logic sw, input logic [15:0] dv,
                       input logic [15:0] sv, input logic [15:0] off, input logic [3:0] len,
                       input string tag);
    exp_t e;
    logic w, ok, badi;
    logic [15:0] mask, res;
    @(negedge clk);
    in_valid = v; op = o; dst_is_reg = dr; dst_reg_wide = dw; src_kind = sk;
    src_reg_wide = sw; dst_val = dv; src_val = sv; jmp_off = off; inst_len = len;
    ok = 1'b1;
    if (dr) w = dw;
    else if (sk == 2'd0) w = sw;
    else if (sk == 2'd1) w = 1'b0;
    else if (sk == 2'd2) w = 1'b1;
    else begin w = 1'b0; ok = 1'b0; end
    badi = (o > 3'd4) || (o != 3'd4 && !ok);
    mask = w ? 16'hFFFF : 16'h00FF;
    if (o == 3'd0) res = sv & mask;
    else if (o == 3'd1) res = (dv + sv) & mask;
    else res = (dv - sv) & mask;
    e.wb_en = 1'b0; e.err = 1'b0;
    if (v && badi) e.err = 1'b1;
    else if (v) begin
      if (o == 3'd4) m_ip = m_zf ? m_ip + {12'd0, len} : m_ip + off;
      else begin
        m_ip = m_ip + {12'd0, len};
        m_wb = res; m_wide = w;
        e.wb_en = (o != 3'd3);
        if (o != 3'd0) begin
          m_zf = (res == 16'd0);
          m_sf = w ? res[15] : res[7];
        end
      end
    end
    e.wb_data = m_wb; e.wb_wide = m_wide; e.zf = m_zf; e.sf = m_sf; e.ip = m_ip; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wb_en !== e.wb_en || wb_data !== e.wb_data || wb_wide !== e.wb_wide ||
            zf !== e.zf || sf !== e.sf || ip !== e.ip || err !== e.err) begin
          failures++;
          $display("FAIL %s: got wb_en=%b wb_data=%h wide=%b zf=%b sf=%b ip=%h err=%b exp wb_en=%b wb_data=%h wide=%b zf=%b sf=%b ip=%h err=%b",
                   e.tag, wb_en, wb_data, wb_wide, zf, sf, ip, err,
                   e.wb_en, e.wb_data, e.wb_wide, e.zf, e.sf, e.ip, e.err);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wb_en !== 0 || wb_data !== 0 || wb_wide !== 0 || zf !== 0 || sf !== 0 || ip !== 0 || err !== 0) begin
      failures++;
      $display("FAIL R10 reset: got ip=%h zf=%b sf=%b wb_en=%b err=%b exp all zero", ip, zf, sf, wb_en, err);
    end
    rst_n = 1'b1;
    issue(1, 3'd0, 1, 1, 2'd0, 1, 16'h1111, 16'hBEEF, 0, 4'd2, "R1 copy word reg");
    issue(1, 3'd0, 1, 0, 2'd2, 1, 16'h0, 16'h12AB, 0, 4'd3, "R1 copy byte dst");
    issue(1, 3'd1, 1, 1, 2'd0, 1, 16'h1234, 16'h0101, 0, 4'd2, "R2 add word");
    issue(1, 3'd1, 1, 0, 2'd0, 0, 16'h00F0, 16'h0010, 0, 4'd2, "R4 byte add wraps to zero");
    issue(1, 3'd0, 1, 1, 2'd1, 0, 16'h0, 16'h0007, 0, 4'd3, "R1 copy keeps zf");
    issue(1, 3'd2, 1, 1, 2'd2, 1, 16'h0005, 16'h0006, 0, 4'd4, "R5 word sub negative");
    issue(1, 3'd2, 1, 0, 2'd1, 0, 16'h0010, 16'h0011, 0, 4'd3, "R5 byte sub bit7");
    issue(1, 3'd3, 1, 1, 2'd0, 1, 16'h4242, 16'h4242, 0, 4'd2, "R3 compare equal no wb");
    issue(1, 3'd4, 0, 0, 2'd0, 0, 0, 0, 16'hFFF0, 4'd2, "R7 branch not taken");
    issue(1, 3'd1, 1, 1, 2'd2, 1, 16'h0001, 16'h0001, 0, 4'd4, "R2 add clears zf");
    issue(1, 3'd4, 0, 0, 2'd0, 0, 0, 0, 16'hFFFA, 4'd2, "R7 branch taken backward");
    issue(1, 3'd4, 0, 0, 2'd0, 0, 0, 0, 16'h0020, 4'd2, "R7 branch taken forward");
    issue(1, 3'd0, 0, 1, 2'd0, 0, 16'h0, 16'hA5C3, 0, 4'd2, "R6 mem dst byte src reg");
    issue(1, 3'd1, 0, 0, 2'd2, 0, 16'h7FFF, 16'h0001, 0, 4'd6, "R6 mem dst imm16");
    issue(1, 3'd1, 0, 0, 2'd1, 1, 16'h007F, 16'h0001, 0, 4'd5, "R6 mem dst imm8");
    issue(1, 3'd6, 1, 1, 2'd0, 1, 16'h0000, 16'h0000, 0, 4'd2, "R9 illegal opcode");
    issue(1, 3'd2, 0, 1, 2'd3, 1, 16'h0003, 16'h0003, 0, 4'd2, "R9 memory to memory");
    issue(0, 3'd1, 1, 1, 2'd0, 1, 16'h0003, 16'h0005, 0, 4'd7, "R11 idle cycle");
    issue(1, 3'd3, 1, 0, 2'd0, 0, 16'h1234, 16'h5634, 0, 4'd2, "R4 byte compare ignores upper");
    issue(1, 3'd2, 1, 1, 2'd0, 1, 16'h8000, 16'h0001, 0, 4'd2, "R2 sub word");
    issue(0, 3'd0, 0, 0, 2'd0, 0, 0, 0, 0, 4'd0, "R8 idle tail");
    @(negedge clk); in_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule